// File: doc/BRIEF.md
# Register Remap Key-Value Table

This block turns a short ordered list of register-remap configuration entries into two full lookup tables, one for integer architectural registers and one for floating-point registers. Each configuration entry names a key register, the table it belongs to, a physical start register, an element-width code, a vector flag, a packed-SIMD flag and a reserved bank bit. Instruction issue logic presents an architectural register number together with an int/FP select on one of several combinational lookup ports. It gets back the register to use, together with the element width and the flags configured for that register.

Configuration entries are written through a small write port. Any write, or an explicit rebuild request, clears both tables and replays the entries one per cycle in ascending index order. When two entries name the same key in the same table, the later one wins. While the replay runs, `busy` is high and every lookup returns the plain scalar identity mapping. An entry that carries the reserved bank value is left out of the tables and raises a sticky error flag.

Top module: `remap_kv_table`

## Requirements
- R1: After reset `busy` and `cfg_err` are 0, and every lookup returns its own register number with width code 0, vector flag 0, packed flag 0 and bank 0.
- R2: `cfg_data` is packed as bit 15 bank, bit 14 table select (0 integer, 1 FP), bits 13:9 key register, bits 8:4 start register, bits 3:2 width code (0 default, 1 half of default, 2 = 8 bits, 3 = 16 bits), bit 1 packed-SIMD flag and bit 0 vector flag.
- R3: A rebuild request raises `busy` at the next clock edge. `busy` then stays high for exactly 16 cycles, one entry being applied per cycle in index order 0 to 15.
- R4: While `busy` is high, every lookup returns the scalar identity mapping: its own register number, width 0, vector 0, packed 0.
- R5: Once the tables are built, a lookup of a key whose entry has the vector flag set returns that entry's start register, width code and packed flag, with vector 1.
- R6: A lookup of a configured key whose vector flag is 0 returns the register number itself, with vector 0, but still reports the entry's width code and packed flag.
- R7: Integer and FP tables are independent: an entry affects only lookups whose select matches its table select bit.
- R8: When several entries share a key and a table select, the one with the highest index determines the lookup result.
- R9: Both tables are cleared when a rebuild starts, so a key that no longer appears in any entry returns the identity mapping afterwards.
- R10: An entry with bank bit 1 is not applied (its key keeps its previous mapping for that rebuild) and sets `cfg_err`. `cfg_err` stays set until the next rebuild starts, which clears it.
- R11: A write to any configuration entry starts a rebuild by itself. A write made while a rebuild runs restarts it from entry 0, giving 16 more busy cycles.
- R12: Every lookup port works independently and at the same time as the others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_we | input | 1 | Configuration entry write strobe |
| cfg_idx | input | 4 | Index of the entry being written |
| cfg_data | input | 16 | Entry contents, packed as in R2 |
| rebuild_req | input | 1 | Request to rebuild the tables without writing |
| busy | output | 1 | High while the tables are being rebuilt |
| cfg_err | output | 1 | Sticky flag: an entry with the reserved bank value was seen |
| lk_fp | input | 3 | Per-port table select (1 = FP) |
| lk_reg | input | 15 | Per-port architectural register, 5 bits each |
| lk_phys | output | 15 | Per-port resulting register, 5 bits each |
| lk_ew | output | 6 | Per-port width code, 2 bits each |
| lk_vec | output | 3 | Per-port vector flag |
| lk_packed | output | 3 | Per-port packed-SIMD flag |
| lk_bank | output | 3 | Per-port bank bit |

## Verification
The bench builds the block with its default parameters: 16 configuration entries, three lookup ports and 5-bit register numbers. These values make the full 16-cycle replay observable, so `busy` can be counted and probed mid-way. They also bring keys 0 and 31 at both ends of each 32-entry table within reach, and let three different lookups be compared in the same cycle. Overlapping keys, a reserved-bank entry, a write landing mid-rebuild and removal of a mapping on rewrite are all reached with this one configuration.

// File: rtl/remap_kv_pkg.sv
package remap_kv_pkg;

  localparam int RIDX_W = 5;
  localparam int NREGS  = 1 << RIDX_W;

  typedef enum logic [1:0] {
    EW_DEFAULT = 2'd0,
    EW_HALF    = 2'd1,
    EW_BYTE    = 2'd2,
    EW_SHORT   = 2'd3
  } ew_e;

  // configuration entry as written by software
  typedef struct packed {
    logic              bank;
    logic              is_fp;
    logic [RIDX_W-1:0] key;
    logic [RIDX_W-1:0] start;
    ew_e               ew;
    logic              packed_simd;
    logic              is_vec;
  } cfg_ent_t;

  // expanded table entry
  typedef struct packed {
    logic              en;
    logic              bank;
    logic [RIDX_W-1:0] start;
    ew_e               ew;
    logic              packed_simd;
    logic              is_vec;
  } map_ent_t;

  localparam int CFG_W = $bits(cfg_ent_t);

endpackage

// File: rtl/remap_cfg_store.sv
module remap_cfg_store
  import remap_kv_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int IDX_W       = $clog2(NUM_ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  cfg_ent_t         wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output cfg_ent_t         rd_data
);

  cfg_ent_t ent_q [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] ent_we;

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_ent
    assign ent_we[e] = wr_en && (wr_idx == IDX_W'(e));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_q[e] <= '0;
      end else if (ent_we[e]) begin
        ent_q[e] <= wr_data;
      end
    end
  end

  assign rd_data = ent_q[rd_idx];

  AST_ONE_ENTRY_WRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ent_we)); // R11

endmodule

// File: rtl/remap_rebuild_ctl.sv
module remap_rebuild_ctl #(
  parameter int NUM_ENTRIES = 16,
  parameter int IDX_W       = $clog2(NUM_ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             cur_bank_i,
  output logic             busy_o,
  output logic [IDX_W-1:0] ptr_o,
  output logic             clear_o,
  output logic             wr_o,
  output logic             err_o
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_ENTRIES - 1);

  logic             busy_q, busy_d;
  logic [IDX_W-1:0] ptr_q, ptr_d;
  logic             err_q, err_d;

  always_comb begin
    busy_d  = busy_q;
    ptr_d   = ptr_q;
    err_d   = err_q;
    clear_o = 1'b0;
    wr_o    = 1'b0;
    if (start_i) begin
      busy_d  = 1'b1;
      ptr_d   = '0;
      err_d   = 1'b0;
      clear_o = 1'b1;
    end else if (busy_q) begin
      if (cur_bank_i) begin
        err_d = 1'b1;
      end else begin
        wr_o = 1'b1;
      end
      if (ptr_q == LAST) begin
        busy_d = 1'b0;
      end else begin
        ptr_d = ptr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      ptr_q  <= '0;
      err_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      ptr_q  <= ptr_d;
      err_q  <= err_d;
    end
  end

  assign busy_o = busy_q;
  assign ptr_o  = ptr_q;
  assign err_o  = err_q;

  AST_START_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (busy_q && ptr_q == '0)); // R3
  AST_DONE_AT_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> ($past(ptr_q) == LAST)); // R3
  AST_PTR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_q <= LAST); // R3
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !start_i) |=> err_q); // R10

endmodule

// File: rtl/remap_map_table.sv
module remap_map_table
  import remap_kv_pkg::*;
#(
  parameter int NUM_LK = 3
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           clear_i,
  input  logic                           wr_i,
  input  cfg_ent_t                       wr_ent_i,
  input  logic                           busy_i,
  input  logic [NUM_LK-1:0]              lk_fp_i,
  input  logic [NUM_LK-1:0][RIDX_W-1:0]  lk_reg_i,
  output logic [NUM_LK-1:0][RIDX_W-1:0]  lk_phys_o,
  output logic [NUM_LK-1:0][1:0]         lk_ew_o,
  output logic [NUM_LK-1:0]              lk_vec_o,
  output logic [NUM_LK-1:0]              lk_packed_o,
  output logic [NUM_LK-1:0]              lk_bank_o
);

  map_ent_t tbl_q [2][NREGS];
  map_ent_t tbl_d [2][NREGS];
  logic     tbl_we;

  assign tbl_we = clear_i || wr_i;

  always_comb begin
    tbl_d = tbl_q;
    if (clear_i) begin
      for (int t = 0; t < 2; t++) begin
        for (int r = 0; r < NREGS; r++) begin
          tbl_d[t][r] = '0;
        end
      end
    end else if (wr_i) begin
      tbl_d[wr_ent_i.is_fp][wr_ent_i.key] = '{
        en:          1'b1,
        bank:        wr_ent_i.bank,
        start:       wr_ent_i.start,
        ew:          wr_ent_i.ew,
        packed_simd: wr_ent_i.packed_simd,
        is_vec:      wr_ent_i.is_vec
      };
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int t = 0; t < 2; t++) begin
        for (int r = 0; r < NREGS; r++) begin
          tbl_q[t][r] <= '0;
        end
      end
    end else if (tbl_we) begin
      tbl_q <= tbl_d;
    end
  end

  for (genvar p = 0; p < NUM_LK; p++) begin : g_port
    map_ent_t hit;
    logic     use_hit;

    assign hit     = tbl_q[lk_fp_i[p]][lk_reg_i[p]];
    assign use_hit = hit.en && !busy_i;

    assign lk_phys_o[p]   = (use_hit && hit.is_vec) ? hit.start : lk_reg_i[p];
    assign lk_ew_o[p]     = use_hit ? hit.ew : EW_DEFAULT;
    assign lk_vec_o[p]    = use_hit && hit.is_vec;
    assign lk_packed_o[p] = use_hit && hit.packed_simd;
    assign lk_bank_o[p]   = use_hit && hit.bank;

    AST_BUSY_IDENTITY: assert property (@(posedge clk) disable iff (!rst_n)
      busy_i |-> (lk_phys_o[p] == lk_reg_i[p] && !lk_vec_o[p] && !lk_packed_o[p])); // R4
    AST_SCALAR_SELF: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_vec_o[p] |-> (lk_phys_o[p] == lk_reg_i[p])); // R6
    AST_BANK_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_bank_o[p]); // R10
  end

  AST_NO_RSVD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |-> !wr_ent_i.bank); // R10
  AST_CLEAR_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |-> !wr_i); // R9

endmodule

// File: rtl/remap_kv_table.sv
module remap_kv_table
  import remap_kv_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int NUM_LK      = 3,
  localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [IDX_W-1:0]         cfg_idx,
  input  logic [CFG_W-1:0]         cfg_data,
  input  logic                     rebuild_req,
  output logic                     busy,
  output logic                     cfg_err,
  input  logic [NUM_LK-1:0]        lk_fp,
  input  logic [NUM_LK*RIDX_W-1:0] lk_reg,
  output logic [NUM_LK*RIDX_W-1:0] lk_phys,
  output logic [NUM_LK*2-1:0]      lk_ew,
  output logic [NUM_LK-1:0]        lk_vec,
  output logic [NUM_LK-1:0]        lk_packed,
  output logic [NUM_LK-1:0]        lk_bank
);

  logic             start;
  logic             clear;
  logic             apply;
  logic [IDX_W-1:0] ptr;
  cfg_ent_t         cur_ent;

  logic [NUM_LK-1:0][RIDX_W-1:0] reg_v;
  logic [NUM_LK-1:0][RIDX_W-1:0] phys_v;
  logic [NUM_LK-1:0][1:0]        ew_v;

  // a write makes the tables stale, so it restarts the replay
  assign start = cfg_we || rebuild_req;

  remap_cfg_store #(
    .NUM_ENTRIES (NUM_ENTRIES),
    .IDX_W       (IDX_W)
  ) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_we),
    .wr_idx  (cfg_idx),
    .wr_data (cfg_ent_t'(cfg_data)),
    .rd_idx  (ptr),
    .rd_data (cur_ent)
  );

  remap_rebuild_ctl #(
    .NUM_ENTRIES (NUM_ENTRIES),
    .IDX_W       (IDX_W)
  ) u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start),
    .cur_bank_i (cur_ent.bank),
    .busy_o     (busy),
    .ptr_o      (ptr),
    .clear_o    (clear),
    .wr_o       (apply),
    .err_o      (cfg_err)
  );

  assign reg_v   = lk_reg;
  assign lk_phys = phys_v;
  assign lk_ew   = ew_v;

  remap_map_table #(
    .NUM_LK (NUM_LK)
  ) u_tbl (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear_i     (clear),
    .wr_i        (apply),
    .wr_ent_i    (cur_ent),
    .busy_i      (busy),
    .lk_fp_i     (lk_fp),
    .lk_reg_i    (reg_v),
    .lk_phys_o   (phys_v),
    .lk_ew_o     (ew_v),
    .lk_vec_o    (lk_vec),
    .lk_packed_o (lk_packed),
    .lk_bank_o   (lk_bank)
  );

  AST_WRITE_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> busy); // R11

endmodule

// File: tb/tb_remap_kv_table.sv
module tb_remap_kv_table;

  localparam int CLK_PERIOD = 10;
  localparam int NLK        = 3;
  localparam int NVEC       = 8;

  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic [3:0]  cfg_idx;
  logic [15:0] cfg_data;
  logic        rebuild_req;
  logic        busy;
  logic        cfg_err;
  logic [NLK-1:0]   lk_fp;
  logic [NLK*5-1:0] lk_reg;
  logic [NLK*5-1:0] lk_phys;
  logic [NLK*2-1:0] lk_ew;
  logic [NLK-1:0]   lk_vec;
  logic [NLK-1:0]   lk_packed;
  logic [NLK-1:0]   lk_bank;

  int compared   = 0;
  int mismatched = 0;
  bit finished   = 0;

  remap_kv_table dut (
    .clk (clk), .rst_n (rst_n),
    .cfg_we (cfg_we), .cfg_idx (cfg_idx), .cfg_data (cfg_data),
    .rebuild_req (rebuild_req), .busy (busy), .cfg_err (cfg_err),
    .lk_fp (lk_fp), .lk_reg (lk_reg), .lk_phys (lk_phys), .lk_ew (lk_ew),
    .lk_vec (lk_vec), .lk_packed (lk_packed), .lk_bank (lk_bank)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // lookup vectors: {fp, reg, exp_phys, exp_ew, exp_vec, exp_packed}
  localparam logic [14:0] VECS [NVEC] = '{
    {1'b0, 5'd3,  5'd12, 2'd0, 1'b1, 1'b1},  // R8 later entry wins
    {1'b1, 5'd3,  5'd20, 2'd3, 1'b1, 1'b1},  // R7 fp table
    {1'b0, 5'd5,  5'd5,  2'd1, 1'b0, 1'b1},  // R6 scalar entry
    {1'b1, 5'd9,  5'd9,  2'd0, 1'b0, 1'b0},  // R10 skipped entry
    {1'b1, 5'd5,  5'd5,  2'd0, 1'b0, 1'b0},  // R7 int-only key
    {1'b0, 5'd31, 5'd0,  2'd2, 1'b1, 1'b0},  // R5 top key
    {1'b0, 5'd4,  5'd4,  2'd0, 1'b0, 1'b0},  // R5 unconfigured
    {1'b1, 5'd31, 5'd31, 2'd0, 1'b0, 1'b0}   // R7 fp unconfigured
  };

  function automatic logic [15:0] mk(input logic bank, input logic fp,
                                     input logic [4:0] key, input logic [4:0] st,
                                     input logic [1:0] ew, input logic pk,
                                     input logic vec);
    return {bank, fp, key, st, ew, pk, vec};  // R2 layout
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    end
  endtask

  task automatic cfg_write(input int idx, input logic [15:0] d);
    cfg_idx  = 4'(idx);
    cfg_data = d;
    cfg_we   = 1'b1;
    @(negedge clk);
    cfg_we   = 1'b0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy && n < 1000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic look(input int p, input logic fp, input logic [4:0] r);
    lk_fp[p]       = fp;
    lk_reg[p*5+:5] = r;
  endtask

  task automatic expect_port(input string req, input int p, input int phys,
                             input int ew, input int vec, input int pk);
    chk({req, " phys"},   int'(lk_phys[p*5+:5]), phys);
    chk({req, " ew"},     int'(lk_ew[p*2+:2]),   ew);
    chk({req, " vec"},    int'(lk_vec[p]),       vec);
    chk({req, " packed"}, int'(lk_packed[p]),    pk);
    chk({req, " bank"},   int'(lk_bank[p]),      0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    int n;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_idx = '0; cfg_data = '0;
    rebuild_req = 1'b0; lk_fp = '0; lk_reg = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 busy", int'(busy), 0);
    chk("R1 err", int'(cfg_err), 0);
    look(0, 1'b0, 5'd3); look(1, 1'b1, 5'd31); look(2, 1'b0, 5'd0);
    #1;
    expect_port("R1 p0", 0, 3, 0, 0, 0);
    expect_port("R1 p1", 1, 31, 0, 0, 0);

    // configuration; each write restarts the replay (R11)
    cfg_write(0, mk(0, 0, 5'd3,  5'd10, 2'd2, 0, 1));
    cfg_write(1, mk(0, 1, 5'd3,  5'd20, 2'd3, 1, 1));
    cfg_write(2, mk(0, 0, 5'd5,  5'd7,  2'd1, 1, 0));
    cfg_write(3, mk(0, 0, 5'd3,  5'd12, 2'd0, 1, 1));
    cfg_write(4, mk(1, 1, 5'd9,  5'd1,  2'd0, 0, 1));
    cfg_write(5, mk(0, 0, 5'd31, 5'd0,  2'd2, 0, 1));
    chk("R11 busy after write", int'(busy), 1);
    wait_idle(n);
    chk("R3 busy cycles", n, 16);
    chk("R10 err set", int'(cfg_err), 1);

    // table-driven lookups on all ports at once (R5..R8, R12)
    for (int i = 0; i < NVEC; i++) begin
      for (int p = 0; p < NLK; p++) begin
        logic [14:0] v;
        v = VECS[(i + p) % NVEC];
        look(p, v[14], v[13:9]);
      end
      #1;
      for (int p = 0; p < NLK; p++) begin
        logic [14:0] v;
        v = VECS[(i + p) % NVEC];
        expect_port($sformatf("R12 vec%0d port%0d", (i + p) % NVEC, p), p,
                    int'(v[8:4]), int'(v[3:2]), int'(v[1]), int'(v[0]));
      end
      @(negedge clk);
    end

    // R10 sticky while idle
    repeat (5) @(negedge clk);
    chk("R10 err sticky", int'(cfg_err), 1);

    // R4 identity during rebuild, R10 cleared at start
    rebuild_req = 1'b1;
    @(negedge clk);
    rebuild_req = 1'b0;
    @(negedge clk);
    look(0, 1'b0, 5'd3); look(1, 1'b1, 5'd3);
    #1;
    chk("R4 busy", int'(busy), 1);
    expect_port("R4 p0", 0, 3, 0, 0, 0);
    expect_port("R4 p1", 1, 3, 0, 0, 0);
    chk("R10 err cleared at start", int'(cfg_err), 0);
    wait_idle(n);
    chk("R3 busy cycles req", n, 15);
    chk("R10 err again", int'(cfg_err), 1);

    // R11 write mid-rebuild restarts; R9 removed key; R10 fixed entry
    cfg_write(4, mk(0, 1, 5'd9, 5'd2, 2'd1, 0, 1));
    repeat (3) @(negedge clk);
    cfg_write(5, mk(0, 0, 5'd0, 5'd0, 2'd0, 0, 0));
    wait_idle(n);
    chk("R11 restart cycles", n, 16);
    chk("R10 err clear", int'(cfg_err), 0);
    look(0, 1'b1, 5'd9); look(1, 1'b0, 5'd31); look(2, 1'b0, 5'd3);
    #1;
    expect_port("R10 fp9", 0, 2, 1, 1, 0);
    expect_port("R9 int31", 1, 31, 0, 0, 0);
    expect_port("R8 int3", 2, 12, 0, 1, 1);

    summary();
    $finish;
  end

endmodule